// File: doc/BRIEF.md
# PCM frame synchronization supervisor

This block supervises a serial PCM interface. It oversamples the PCM bit clock and the frame pulse with a fast system clock, measures how many active bit-clock edges separate successive frame pulses, and compares that figure with the length a frame should have for the configured time-slot count and clocking mode. A run of correct frames moves it into the synchronized state; a single frame with a missing or extra clock period takes it out again.

Alongside the supervision it keeps a frame position counter that is loaded from a programmable bit offset whenever a frame pulse is taken. The counter therefore reports the current slot and bit number of the external frame even when the pulse does not mark bit 0. A level status output shows whether the interface is in sync, and a one-cycle change strobe fires on every gain or loss of sync for use as an interrupt source.

Configuration selects single or double clocking, the number of slots (8 to 32), the offset and which bit-clock edge is active. Configuration is expected to be stable while the block runs and changed only under reset.

Top module: `pcm_sync_supervisor`

## Requirements
- R1: The expected frame length, in active bit-clock edges, is cfg_slots × 8 with cfg_double = 0 and cfg_slots × 16 with cfg_double = 1, for cfg_slots from 8 to 32 (e.g. 512 for 32 slots, double clock).
- R2: sync_status goes to 1 on the frame pulse that completes the second consecutive frame of exactly the expected length, and not earlier.
- R3: A frame pulse seen when fewer than the expected number of edges have passed since the previous pulse is a bad frame and returns the block to the unsynchronized state.
- R4: When the expected number of edges has passed and a further active edge arrives without a frame pulse, that edge is a bad frame, drops sync, and restarts the frame measurement and position counter as if a pulse had been seen there.
- R5: sync_status is a level that only changes on a transition; sync_chg is high for exactly one system clock in the cycle sync_status changes, once per gain and once per loss.
- R6: On a taken frame pulse the position is loaded with cfg_offset (single clock) or 2 × cfg_offset (double clock) clock periods and then advances by one per active edge, wrapping at the expected length; bit_pos is position mod 8 in bit units (position divided by 2 in double mode) and slot_pos is the bit index divided by 8.
- R7: cfg_fall_edge = 0 makes the rising bit-clock edge active, 1 the falling edge; frame_sync is taken only at the active edge, so a pulse present only around the inactive edge is ignored.
- R8: The first frame pulse after reset only starts the measurement and yields no verdict; no edge before it counts toward a frame.
- R9: After reset sync_status = 0, sync_chg = 0, bit_pos = 0 and slot_pos = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the PCM bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pcm_clk | input | 1 | PCM bit clock, oversampled |
| frame_sync | input | 1 | PCM frame pulse, taken at the active bit-clock edge |
| cfg_double | input | 1 | 1 = two clock periods per bit |
| cfg_slots | input | 6 | Time slots per frame, 8 to 32 |
| cfg_offset | input | 8 | Bit number marked by the frame pulse, below cfg_slots × 8 |
| cfg_fall_edge | input | 1 | 1 = falling bit-clock edge is active |
| bit_pos | output | 3 | Current bit within the slot |
| slot_pos | output | 5 | Current slot within the frame |
| sync_status | output | 1 | 1 while synchronized |
| sync_chg | output | 1 | One-cycle strobe on each sync status change |

## Verification
A bit-clock level driven at a falling system-clock edge reaches the input samplers on the next rising edge, the frame counter's verdict strobe one edge later and the sync state with its change strobe one edge after that, so status and strobe are due three system clocks after the active PCM edge and the position outputs two clocks after it. The bench holds every PCM clock level for four system clocks and samples all outputs on a falling system-clock edge at the end of that hold, so each check lands after its result is due and before the next PCM edge. Change strobes are counted on every falling edge, so a pulse that is missing, doubled or stretched shows up in the count.

// File: rtl/pcm_sync_pkg.sv
package pcm_sync_pkg;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_ONE_GOOD = 2'd1,
        ST_SYNC     = 2'd2
    } sync_st_e;

    typedef struct packed {
        logic clk_s;
        logic clk_p;
        logic fs_s;
    } smp_regs_t;

    typedef struct packed {
        sync_st_e st;
        logic     chg;
    } fsm_regs_t;

endpackage

// File: rtl/pcm_edge_sampler.sv
module pcm_edge_sampler
    import pcm_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pcm_clk,
    input  logic frame_sync,
    input  logic fall_edge,
    output logic edge_evt,
    output logic fs_at_edge
);
    smp_regs_t r_d, r_q;

    always_comb begin
        r_d.clk_s = pcm_clk;
        r_d.clk_p = r_q.clk_s;
        r_d.fs_s  = frame_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign edge_evt   = fall_edge ? (r_q.clk_p & ~r_q.clk_s) : (~r_q.clk_p & r_q.clk_s);
    assign fs_at_edge = r_q.fs_s;

    // R7
    evt_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> !edge_evt);

endmodule

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter #(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_evt,
    input  logic              fs_at_edge,
    input  logic              dbl,
    input  logic [SLOT_W:0]   slots,
    input  logic [SLOT_W+2:0] offset,
    output logic              good,
    output logic              bad,
    output logic [2:0]        bit_pos,
    output logic [SLOT_W-1:0] slot_pos
);
    localparam int CNT_W = SLOT_W + 5;

    typedef struct packed {
        logic [CNT_W-1:0] per_cnt;
        logic [CNT_W-1:0] pos;
        logic             armed;
        logic             good;
        logic             bad;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;
    logic [CNT_W-1:0] exp_len, last_idx, preload;

    always_comb begin
        exp_len  = CNT_W'(slots) << (dbl ? 4 : 3);
        last_idx = exp_len - CNT_W'(1);
        preload  = CNT_W'(offset) << (dbl ? 1 : 0);

        r_d      = r_q;
        r_d.good = 1'b0;
        r_d.bad  = 1'b0;
        if (edge_evt) begin
            if (fs_at_edge) begin
                if (r_q.armed) begin
                    if (r_q.per_cnt == last_idx) r_d.good = 1'b1;
                    else                          r_d.bad  = 1'b1;
                end
                r_d.armed   = 1'b1;
                r_d.per_cnt = '0;
                r_d.pos     = preload;
            end else if (r_q.armed && r_q.per_cnt == last_idx) begin
                r_d.bad     = 1'b1;
                r_d.per_cnt = '0;
                r_d.pos     = preload;
            end else begin
                if (r_q.armed) r_d.per_cnt = r_q.per_cnt + CNT_W'(1);
                r_d.pos = (r_q.pos == last_idx) ? '0 : r_q.pos + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign good     = r_q.good;
    assign bad      = r_q.bad;
    assign bit_pos  = dbl ? r_q.pos[3:1] : r_q.pos[2:0];
    assign slot_pos = dbl ? r_q.pos[SLOT_W+3:4] : r_q.pos[SLOT_W+2:3];

    // R3
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(good && bad));

    // R4
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.per_cnt < exp_len);

    // R6
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pos < exp_len);

    // R8
    no_verdict_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good || bad) |-> $past(r_q.armed));

endmodule

// File: rtl/pcm_sync_fsm.sv
module pcm_sync_fsm
    import pcm_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic good,
    input  logic bad,
    output logic sync_status,
    output logic sync_chg
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d.st = r_q.st;
        if (bad) begin
            r_d.st = ST_HUNT;
        end else if (good) begin
            case (r_q.st)
                ST_HUNT:     r_d.st = ST_ONE_GOOD;
                ST_ONE_GOOD: r_d.st = ST_SYNC;
                default:     r_d.st = ST_SYNC;
            endcase
        end
        r_d.chg = (r_d.st == ST_SYNC) != (r_q.st == ST_SYNC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_HUNT, chg: 1'b0};
        else        r_q <= r_d;
    end

    assign sync_status = (r_q.st == ST_SYNC);
    assign sync_chg    = r_q.chg;

    // R2
    gain_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_status) |-> $past(r_q.st == ST_ONE_GOOD) && $past(good));

    // R3
    bad_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (r_q.st == ST_HUNT));

    // R5
    chg_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_chg == (sync_status != $past(sync_status)));

    // R5
    chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_chg |=> !sync_chg);

endmodule

// File: rtl/pcm_sync_supervisor.sv
module pcm_sync_supervisor #(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pcm_clk,
    input  logic              frame_sync,
    input  logic              cfg_double,
    input  logic [SLOT_W:0]   cfg_slots,
    input  logic [SLOT_W+2:0] cfg_offset,
    input  logic              cfg_fall_edge,
    output logic [2:0]        bit_pos,
    output logic [SLOT_W-1:0] slot_pos,
    output logic              sync_status,
    output logic              sync_chg
);
    logic edge_evt, fs_at_edge, good, bad;

    pcm_edge_sampler u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .pcm_clk    (pcm_clk),
        .frame_sync (frame_sync),
        .fall_edge  (cfg_fall_edge),
        .edge_evt   (edge_evt),
        .fs_at_edge (fs_at_edge)
    );

    pcm_frame_counter #(.SLOT_W(SLOT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_evt   (edge_evt),
        .fs_at_edge (fs_at_edge),
        .dbl        (cfg_double),
        .slots      (cfg_slots),
        .offset     (cfg_offset),
        .good       (good),
        .bad        (bad),
        .bit_pos    (bit_pos),
        .slot_pos   (slot_pos)
    );

    pcm_sync_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .good        (good),
        .bad         (bad),
        .sync_status (sync_status),
        .sync_chg    (sync_chg)
    );

endmodule

// File: tb/tb_pcm_sync_supervisor.sv
`timescale 1ns/1ps
module tb_pcm_sync_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pcm_clk = 1'b0;
    logic       frame_sync = 1'b0;
    logic       cfg_double = 1'b0;
    logic [5:0] cfg_slots = 6'd8;
    logic [7:0] cfg_offset = 8'd0;
    logic       cfg_fall_edge = 1'b0;
    logic [2:0] bit_pos;
    logic [4:0] slot_pos;
    logic       sync_status, sync_chg;

    int n_chk = 0, n_bad = 0, chg_cnt = 0;

    always #2.5 clk = ~clk;

    pcm_sync_supervisor dut (
        .clk(clk), .rst_n(rst_n), .pcm_clk(pcm_clk), .frame_sync(frame_sync),
        .cfg_double(cfg_double), .cfg_slots(cfg_slots), .cfg_offset(cfg_offset),
        .cfg_fall_edge(cfg_fall_edge), .bit_pos(bit_pos), .slot_pos(slot_pos),
        .sync_status(sync_status), .sync_chg(sync_chg)
    );

    always @(negedge clk) if (rst_n && sync_chg) chg_cnt++;

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic do_reset(input logic dbl, input int slots, input int ofs, input logic fall);
        @(negedge clk);
        rst_n = 1'b0; pcm_clk = 1'b0; frame_sync = 1'b0;
        cfg_double = dbl; cfg_slots = 6'(slots); cfg_offset = 8'(ofs); cfg_fall_edge = fall;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chg_cnt = 0;
        repeat (2) @(negedge clk);
    endtask

    // one PCM clock period; narrow=1 holds frame_sync only during the high phase
    task automatic pcyc(input logic fs, input logic narrow = 1'b0);
        frame_sync = fs; pcm_clk = 1'b1;
        repeat (4) @(negedge clk);
        if (narrow) frame_sync = 1'b0;
        pcm_clk = 1'b0;
        repeat (4) @(negedge clk);
        frame_sync = 1'b0;
    endtask

    task automatic frame(input int n);
        pcyc(1'b1);
        for (int i = 1; i < n; i++) pcyc(1'b0);
    endtask

    function automatic int exp_len(input logic dbl, input int slots);
        return dbl ? slots * 16 : slots * 8;
    endfunction

    task automatic check_pos(input string tag, input logic dbl, input int slots, input int ofs, input int k);
        int m, e, p;
        m = dbl ? 2 : 1;
        e = exp_len(dbl, slots);
        p = (ofs * m + k) % e;
        check({tag, " bit"},  int'(bit_pos),  (p / m) % 8);
        check({tag, " slot"}, int'(slot_pos), p / (8 * m));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int sl [4] = '{8, 13, 24, 32};

        // R9 reset state
        do_reset(1'b0, 8, 0, 1'b0);
        check("R9 sync", sync_status, 0);
        check("R9 chg", sync_chg, 0);
        check("R9 bit", bit_pos, 0);
        check("R9 slot", slot_pos, 0);

        // R8 / R2 gain on second good frame
        frame(64);
        check("R8 first pulse no verdict", sync_status, 0);
        frame(64);
        check("R2 one good frame", sync_status, 0);
        pcyc(1'b1);
        check("R2 sync after two", sync_status, 1);
        check("R5 one chg on gain", chg_cnt, 1);

        // R3 early pulse
        for (int i = 1; i < 63; i++) pcyc(1'b0);
        pcyc(1'b1);
        check("R3 early pulse drops", sync_status, 0);
        check("R5 chg on loss", chg_cnt, 2);

        // regain then R4 missing pulse
        frame(64); frame(64); pcyc(1'b1);
        check("R2 regain", sync_status, 1);
        for (int i = 1; i < 64; i++) pcyc(1'b0);
        check("R4 still sync at boundary", sync_status, 1);
        pcyc(1'b0);
        check("R4 missing pulse drops", sync_status, 0);
        check("R5 chg count", chg_cnt, 4);
        // restart at the overflow edge: 63 more idle edges then pulse is good
        for (int i = 1; i < 64; i++) pcyc(1'b0);
        frame(64); pcyc(1'b1);
        check("R4 restart measured from overflow", sync_status, 1);

        // R6 position with offset
        do_reset(1'b0, 8, 13, 1'b0);
        pcyc(1'b1);
        check_pos("R6 single k0", 1'b0, 8, 13, 0);
        for (int i = 0; i < 20; i++) pcyc(1'b0);
        check_pos("R6 single k20", 1'b0, 8, 13, 20);
        for (int i = 0; i < 40; i++) pcyc(1'b0);
        check_pos("R6 single wrap", 1'b0, 8, 13, 60);
        do_reset(1'b1, 12, 50, 1'b0);
        pcyc(1'b1);
        for (int i = 0; i < 200; i++) pcyc(1'b0);
        check_pos("R6 double k200", 1'b1, 12, 50, 200);

        // R7 falling edge: narrow pulses missed, wide pulses taken
        do_reset(1'b0, 8, 0, 1'b1);
        for (int f = 0; f < 3; f++) begin
            pcyc(1'b1, 1'b1);
            for (int i = 1; i < 64; i++) pcyc(1'b0);
        end
        pcyc(1'b1, 1'b1);
        check("R7 narrow pulse ignored", sync_status, 0);
        check("R7 no chg", chg_cnt, 0);
        do_reset(1'b0, 8, 0, 1'b1);
        frame(64); frame(64); pcyc(1'b1);
        check("R7 falling edge sync", sync_status, 1);
        do_reset(1'b0, 8, 0, 1'b0);
        frame(64); frame(64); pcyc(1'b1, 1'b1);
        check("R7 rising edge narrow taken", sync_status, 1);

        // R1 sweep of lengths
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 4; s++) begin
                int e;
                e = exp_len(d[0], sl[s]);
                do_reset(d[0], sl[s], 0, 1'b0);
                frame(e); frame(e); pcyc(1'b1);
                check($sformatf("R1 exact len %0d", e), sync_status, 1);
                do_reset(d[0], sl[s], 0, 1'b0);
                frame(e - 1); frame(e - 1); frame(e - 1); pcyc(1'b1);
                check($sformatf("R1 short len %0d", e), sync_status, 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule